// File: doc/BRIEF.md
# Window-Average Sound Onset Detector

This block watches a stream of 8-bit sound samples and flags the moment a word begins. It sums the accepted samples over consecutive windows of 1024 samples, turns each sum into a window average, and compares that average with the one from the window before. If the two averages differ by more than a threshold supplied at run time, the block emits a one-cycle start pulse. It then holds a capture flag high for the next 5120 accepted samples, so that a downstream store can keep the whole word.

A sample counts only in a cycle where the valid strobe is high, so the block runs at any sample rate below the clock rate. The newest window average is also driven out for display. Further onsets are ignored while a capture is running. The first window after reset serves only as the reference and can never trigger.

Top module: `onset_detector`

## Requirements
- R1: When the 1024th valid sample of a window is accepted, `avg_o` takes the value floor(sum of the window's 1024 samples / 1024) in the next cycle. Samples are summed as unsigned 8-bit values. `avg_o` holds its value at all other times.
- R2: A sample contributes only in a cycle where `smp_valid_i` is high. `smp_data_i` has no effect in any other cycle.
- R3: `start_o` is a pulse one cycle long. It is high in the cycle after the one in which `avg_o` took the new window average.
- R4: A start fires only when |new average − previous average| is strictly greater than `thresh_i`, read as a 9-bit unsigned value. A difference equal to the threshold does not fire.
- R5: `capture_o` rises in the same cycle as `start_o`. It falls after exactly 5120 further valid samples have been accepted, counted from the clock edge that follows the pulse cycle. It never falls in a cycle without a valid sample.
- R6: The first complete window after reset never produces a start, whatever its average.
- R7: While `capture_o` is high, no start is produced. Averaging continues, and comparisons that fall inside the capture are dropped.
- R8: Asserting `rst_n` clears `start_o`, `capture_o` and `avg_o` to 0 at once and restarts window counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid_i | input | 1 | High in each cycle that carries a sample |
| smp_data_i | input | 8 | Sample magnitude, unsigned |
| thresh_i | input | 9 | Onset threshold on the absolute average difference |
| start_o | output | 1 | One-cycle onset pulse |
| capture_o | output | 1 | High while the fixed-length capture runs |
| avg_o | output | 8 | Average of the most recent complete window |

## Verification
If the window sample counter drifts, `avg_o` changes on the wrong sample and the error shows in the very cycle where the next average should appear. That happens at most 1024 valid samples into the stimulus. A corrupted accumulator shows in the first average value after the fault. A faulty comparison or capture counter shows at once as a start pulse that comes one cycle early or late, is missing, or is extra. The bench compares all three outputs with its own model in every cycle, so a wrong internal state is reported within one window of valid samples at most. A capture length that is off by one is also caught when `capture_o` falls.

// File: rtl/onset_pkg.sv
package onset_pkg;
  // absolute difference of two unsigned averages, one bit wider than the inputs
  function automatic logic [8:0] avg_absdiff(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] ea;
    logic [8:0] eb;
    ea = {1'b0, a};
    eb = {1'b0, b};
    return (ea >= eb) ? (ea - eb) : (eb - ea);
  endfunction
endpackage

// File: rtl/onset_rst_sync.sv
module onset_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/onset_win_avg.sv
module onset_win_avg #(
  parameter int SAMPLE_W = 8,
  parameter int WIN_LOG2 = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic [SAMPLE_W-1:0] avg_new_o,
  output logic [SAMPLE_W-1:0] avg_old_o,
  output logic                cmp_req_o
);
  localparam int ACC_W = SAMPLE_W + WIN_LOG2;

  logic [WIN_LOG2-1:0] cnt_q, cnt_d;
  logic [ACC_W-1:0]    acc_q, acc_d;
  logic [SAMPLE_W-1:0] new_q, new_d, old_q, old_d;
  logic                primed_q, primed_d, req_q, req_d;
  logic [ACC_W-1:0]    acc_sum;
  logic                last_smp;

  assign acc_sum  = acc_q + ACC_W'(smp_data_i);
  assign last_smp = (cnt_q == {WIN_LOG2{1'b1}});

  always_comb begin
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    new_d    = new_q;
    old_d    = old_q;
    primed_d = primed_q;
    req_d    = 1'b0;
    if (smp_valid_i) begin
      cnt_d = cnt_q + 1'b1;
      if (last_smp) begin
        acc_d    = '0;
        new_d    = acc_sum[ACC_W-1 -: SAMPLE_W];
        old_d    = new_q;
        primed_d = 1'b1;
        req_d    = primed_q;
      end else begin
        acc_d = acc_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      acc_q    <= '0;
      new_q    <= '0;
      old_q    <= '0;
      primed_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      acc_q    <= acc_d;
      new_q    <= new_d;
      old_q    <= old_d;
      primed_q <= primed_d;
      req_q    <= req_d;
    end
  end

  assign avg_new_o = new_q;
  assign avg_old_o = old_q;
  assign cmp_req_o = req_q;

  // R1
  avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> $stable(avg_new_o));

  // R6
  req_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req_o |-> $past(smp_valid_i));
endmodule

// File: rtl/onset_cmp.sv
module onset_cmp
  import onset_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int THR_W       = 9,
  parameter int CAPTURE_LEN = 5120
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid_i,
  input  logic                cmp_req_i,
  input  logic [SAMPLE_W-1:0] avg_new_i,
  input  logic [SAMPLE_W-1:0] avg_old_i,
  input  logic [THR_W-1:0]    thresh_i,
  output logic                start_o,
  output logic                capture_o
);
  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int CMP_W  = (DIFF_W > THR_W) ? DIFF_W : THR_W;
  localparam int CAP_W  = $clog2(CAPTURE_LEN + 1);

  logic [CAP_W-1:0] cap_q, cap_d;
  logic             start_q, start_d;
  logic [DIFF_W-1:0] diff;
  logic             busy, fire;

  assign diff = DIFF_W'(avg_absdiff(8'(avg_new_i), 8'(avg_old_i)));
  assign busy = (cap_q != '0);
  assign fire = cmp_req_i && !busy && (CMP_W'(diff) > CMP_W'(thresh_i));

  always_comb begin
    start_d = fire;
    cap_d   = cap_q;
    if (fire)                    cap_d = CAP_W'(CAPTURE_LEN);
    else if (smp_valid_i && busy) cap_d = cap_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cap_q   <= cap_d;
      start_q <= start_d;
    end
  end

  assign start_o   = start_q;
  assign capture_o = busy;

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R5
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> capture_o);

  // R5
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_o && !smp_valid_i) |=> capture_o);

  // R7
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !$past(capture_o));
endmodule

// File: rtl/onset_detector.sv
module onset_detector #(
  parameter int SAMPLE_W    = 8,
  parameter int WIN_LOG2    = 10,
  parameter int THR_W       = 9,
  parameter int CAPTURE_LEN = 5120
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  input  logic [THR_W-1:0]    thresh_i,
  output logic                start_o,
  output logic                capture_o,
  output logic [SAMPLE_W-1:0] avg_o
);
  logic                rst_n_int;
  logic [SAMPLE_W-1:0] avg_new, avg_old;
  logic                cmp_req;

  onset_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  onset_win_avg #(.SAMPLE_W(SAMPLE_W), .WIN_LOG2(WIN_LOG2)) u_win_avg (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .avg_new_o   (avg_new),
    .avg_old_o   (avg_old),
    .cmp_req_o   (cmp_req)
  );

  onset_cmp #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .CAPTURE_LEN(CAPTURE_LEN)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .smp_valid_i (smp_valid_i),
    .cmp_req_i   (cmp_req),
    .avg_new_i   (avg_new),
    .avg_old_i   (avg_old),
    .thresh_i    (thresh_i),
    .start_o     (start_o),
    .capture_o   (capture_o)
  );

  assign avg_o = avg_new;
endmodule

// File: tb/onset_detector_bench.sv
module onset_detector_bench;
  localparam int WIN = 1024;
  localparam int CAP = 5120;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = 8'd0;
  logic [8:0] thr = 9'd50;
  logic       start_o, capture_o;
  logic [7:0] avg_o;

  int n_cmp = 0;
  int n_bad = 0;
  int obs_starts = 0;
  int cap_samples = 0;

  // reference model state
  int m_cnt = 0, m_sum = 0, m_new = 0, m_old = 0, m_cap = 0;
  bit m_primed = 0, m_req = 0, m_start = 0;

  always #2 clk = ~clk;

  onset_detector u_onset_detector (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .thresh_i(thr), .start_o(start_o), .capture_o(capture_o), .avg_o(avg_o)
  );

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_sum = 0; m_new = 0; m_old = 0; m_cap = 0;
    m_primed = 0; m_req = 0; m_start = 0;
  endtask

  task automatic model_edge(input bit v, input int d);
    bit fire;
    fire = m_req && (absd(m_new, m_old) > int'(thr)) && (m_cap == 0);
    if (fire) m_cap = CAP;
    else if (v && m_cap > 0) m_cap--;
    m_start = fire;
    m_req = 0;
    if (v) begin
      if (m_cnt == WIN - 1) begin
        m_old = m_new;
        m_new = (m_sum + d) / WIN;
        m_req = m_primed;
        m_primed = 1;
        m_sum = 0;
        m_cnt = 0;
      end else begin
        m_sum += d;
        m_cnt++;
      end
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit v, input logic [7:0] d);
    smp_valid = v;
    smp_data  = d;
    if (v && capture_o) cap_samples++;
    @(posedge clk);
    model_edge(v, int'(d));
    @(negedge clk);
    chk("R1 avg_o", int'(avg_o), m_new);
    chk("R3 start_o", int'(start_o), int'(m_start));
    chk("R5 capture_o", int'(capture_o), int'(m_cap != 0));
    if (start_o) begin
      obs_starts++;
      cap_samples = 0;
    end
  endtask

  task automatic feed_window(input int level, input int spread);
    for (int i = 0; i < WIN; i++) begin
      int x;
      while ($urandom_range(0, 3) == 0) step(1'b0, 8'($urandom)); // R2 garbage on idle cycles
      x = level + int'($urandom_range(0, 2 * spread)) - spread;
      if (x < 0) x = 0;
      if (x > 255) x = 255;
      step(1'b1, 8'(x));
    end
    step(1'b0, 8'($urandom));
    step(1'b0, 8'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int prev_starts;
    void'($urandom(32'h5eed_0417));
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset avg_o", int'(avg_o), 0);
    chk("R8 reset start_o", int'(start_o), 0);
    chk("R8 reset capture_o", int'(capture_o), 0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 8'd0);

    thr = 9'd50;
    feed_window(200, 0);
    chk("R6 first window no start", obs_starts, 0);
    chk("R1 first window avg", int'(avg_o), 200);
    feed_window(200, 0);
    chk("R2 invalid data ignored avg", int'(avg_o), 200);
    feed_window(250, 0);
    chk("R4 diff equal to threshold", obs_starts, 0);
    feed_window(199, 0);
    chk("R4 diff above threshold", obs_starts, 1);
    chk("R5 capture high after start", int'(capture_o), 1);
    feed_window(0, 0);
    feed_window(255, 0);
    feed_window(0, 0);
    feed_window(255, 0);
    chk("R7 no start during capture", obs_starts, 1);
    feed_window(255, 0);
    chk("R5 capture ended", int'(capture_o), 0);
    chk("R5 capture sample count", cap_samples, CAP);
    feed_window(100, 3);
    chk("R4 onset after capture", obs_starts, 2);

    // random phase
    for (int w = 0; w < 16; w++) begin
      thr = 9'($urandom_range(0, 300));
      if (w % 5 == 0) thr = 9'd511;
      feed_window(int'($urandom_range(0, 255)), int'($urandom_range(0, 8)));
    end

    // R8 mid-window reset
    prev_starts = obs_starts;
    for (int i = 0; i < 300; i++) step(1'b1, 8'($urandom));
    rst_n = 1'b0;
    #1;
    chk("R8 async reset avg_o", int'(avg_o), 0);
    chk("R8 async reset start_o", int'(start_o), 0);
    chk("R8 async reset capture_o", int'(capture_o), 0);
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 8'd0);
    thr = 9'd10;
    feed_window(40, 0);
    chk("R8 restart window avg", int'(avg_o), 40);
    chk("R6 first window after reset", obs_starts, prev_starts);
    feed_window(40, 0);
    chk("R4 steady level no start", obs_starts, prev_starts);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule